// File: doc/BRIEF.md
# NAND Bus Access Phase Sequencer

This block sits between an on-chip host request port and an asynchronous NAND flash bus. It turns each host transfer into one or more memory bus cycles. Each memory cycle has three programmable phases: setup, strobe and hold. Write cycles also have a programmable delay before the data bus is driven. The memory data path is 8 or 16 bits wide, chosen by a parameter. A host transfer of 8, 16 or 32 bits is split into as many memory cycles as the width requires. Read parts are packed into the returned word.

The block holds two timing words. One covers common memory space and the other covers attribute memory space, and a per-request space flag picks between them. The timing word is copied when a transfer is accepted, so rewriting it while a transfer runs only affects later transfers. Some transfers cannot be carried out. The block answers these at once with an error and leaves the memory bus untouched.

Top module: `nand_phase_seq`

## Requirements
- R1: While reset is held and after it is released with no request, chip enable, read strobe and write strobe are high (inactive), the data output enable is low, and done and error are low.
- R2: Each memory cycle has three phases. The setup phase has chip enable low and both strobes high. The strobe phase has the read or write strobe low. The hold phase has the strobe high again with the address unchanged. A phase field value N lasts N+1 clock cycles, so 0 gives one cycle.
- R3: The timing word has four fields: setup in bits [W-1:0], strobe in [2W-1:W], hold in [3W-1:2W] and data turn-on delay in [4W-1:3W], where W is the field width. The attribute word is used when the space flag is 1 and the common word when it is 0.
- R4: On 8-bit memory, size codes 0, 1 and 2 (8, 16 and 32 bits) take 1, 2 and 4 memory cycles. Parts go out least significant first, and the memory address is the request address plus the part index.
- R5: On 16-bit memory, size code 1 takes one memory cycle and size code 2 takes two, least significant half first, at consecutive addresses.
- R6: The transfer is refused if the size code is 3, or if it is an 8-bit write on 16-bit memory. A refused transfer raises done and error together for exactly one cycle, starting the cycle after acceptance, and chip enable and both strobes stay high.
- R7: In a write, the data output enable turns on once the number of cycles since the start of that memory cycle's setup phase reaches the delay field. It is off once the hold phase ends. While it is on, the data bus carries the part of the write data for the current memory cycle.
- R8: In a read, the data output enable stays low. The data bus is sampled in the last strobe cycle, and each part lands in its own lanes of the returned word, lane index equal to part index. An 8-bit read on 16-bit memory returns the low byte of the memory word with the upper 24 bits zero.
- R9: Done is high for exactly one cycle, the cycle after the last hold cycle of an allowed transfer. Error is low then, and the returned read data is valid from then until the next transfer starts.
- R10: A request is taken only while the block is idle. A request during a transfer is dropped and starts no memory cycle. Timing words changed during a transfer do not alter that transfer.
- R11: The read and write strobes are never low together, and neither is low while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = invalid |
| req_attr | input | 1 | 1 = attribute space timing, 0 = common space timing |
| req_addr | input | ADDR_W | Memory address of the first part |
| req_wdata | input | 32 | Write data, least significant part first |
| tim_cmn | input | 4*TIM_W | Common space timing word |
| tim_att | input | 4*TIM_W | Attribute space timing word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Refused transfer, set with done |
| rsp_rdata | output | 32 | Assembled read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Memory address/command lines |
| mem_dq_o | output | MEM_W | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | MEM_W | Data bus input value |

## Verification
The hardest cases to reach combine a request that arrives mid-transfer with a timing word rewritten at the same moment. The stimulus starts a four-part write and then, two cycles in, raises the request line with a different address while loading new common-space timings. The scoreboard expects only the strobe pulses, gaps and data of the original transfer, and any extra pulse shows up as an unexpected item. The case where the data turn-on delay is longer than the setup phase is reached by giving the attribute timing word a delay larger than its setup. The bench then expects the output enable to be off at the falling edge of the strobe.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_DONE,
      PH_ERR
   } phase_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;
   localparam logic [1:0] SZ_BAD  = 2'd3;

endpackage

// File: rtl/nps_cfg_pick.sv
module nps_cfg_pick #(
   parameter int TIM_W = 4
) (
   input  logic               sel_att_i,
   input  logic [4*TIM_W-1:0] cmn_i,
   input  logic [4*TIM_W-1:0] att_i,
   output logic [TIM_W-1:0]   setup_o,
   output logic [TIM_W-1:0]   strobe_o,
   output logic [TIM_W-1:0]   hold_o,
   output logic [TIM_W-1:0]   dly_o
);
   logic [4*TIM_W-1:0] word;

   assign word     = sel_att_i ? att_i : cmn_i;
   assign setup_o  = word[TIM_W-1:0];
   assign strobe_o = word[2*TIM_W-1:TIM_W];
   assign hold_o   = word[3*TIM_W-1:2*TIM_W];
   assign dly_o    = word[4*TIM_W-1:3*TIM_W];
endmodule

// File: rtl/nps_phase_fsm.sv
module nps_phase_fsm
   import nand_seq_pkg::*;
#(
   parameter int TIM_W  = 4,
   parameter int PART_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              refuse_i,
   input  logic [PART_W-1:0] last_i,
   input  logic [TIM_W-1:0]  setup_i,
   input  logic [TIM_W-1:0]  strobe_i,
   input  logic [TIM_W-1:0]  hold_i,
   input  logic [TIM_W-1:0]  dly_i,
   output logic              idle_o,
   output logic              active_o,
   output logic              strobe_o,
   output logic              cap_o,
   output logic              oe_win_o,
   output logic              done_o,
   output logic              err_o,
   output logic [PART_W-1:0] part_o
);
   localparam int ACC_W = TIM_W + 2;
   localparam logic [ACC_W-1:0] ACC_MAX = '1;

   phase_e            st_q;
   logic [TIM_W-1:0]  cnt_q, setup_q, strobe_q, hold_q, dly_q;
   logic [PART_W-1:0] part_q, last_q;
   logic [ACC_W-1:0]  acc_q, acc_nx;
   logic              cnt_end;

   assign acc_nx  = (acc_q == ACC_MAX) ? acc_q : acc_q + 1'b1;
   assign cnt_end = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PH_IDLE;
         cnt_q    <= '0;
         setup_q  <= '0;
         strobe_q <= '0;
         hold_q   <= '0;
         dly_q    <= '0;
         part_q   <= '0;
         last_q   <= '0;
         acc_q    <= '0;
      end else begin
         case (st_q)
            PH_IDLE: begin
               if (start_i) begin
                  if (refuse_i) begin
                     st_q <= PH_ERR;
                  end else begin
                     st_q     <= PH_SETUP;
                     cnt_q    <= setup_i;
                     setup_q  <= setup_i;
                     strobe_q <= strobe_i;
                     hold_q   <= hold_i;
                     dly_q    <= dly_i;
                     last_q   <= last_i;
                     part_q   <= '0;
                     acc_q    <= '0;
                  end
               end
            end
            PH_SETUP: begin
               acc_q <= acc_nx;
               if (cnt_end) begin
                  st_q  <= PH_STROBE;
                  cnt_q <= strobe_q;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_STROBE: begin
               acc_q <= acc_nx;
               if (cnt_end) begin
                  st_q  <= PH_HOLD;
                  cnt_q <= hold_q;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt_end) begin
                  if (part_q == last_q) begin
                     st_q <= PH_DONE;
                  end else begin
                     st_q   <= PH_SETUP;
                     part_q <= part_q + 1'b1;
                     cnt_q  <= setup_q;
                     acc_q  <= '0;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
                  acc_q <= acc_nx;
               end
            end
            default: st_q <= PH_IDLE;
         endcase
      end
   end

   assign idle_o   = (st_q == PH_IDLE);
   assign active_o = (st_q == PH_SETUP) || (st_q == PH_STROBE) || (st_q == PH_HOLD);
   assign strobe_o = (st_q == PH_STROBE);
   assign cap_o    = (st_q == PH_STROBE) && cnt_end;
   assign oe_win_o = active_o && (acc_q >= {2'b00, dly_q});
   assign done_o   = (st_q == PH_DONE) || (st_q == PH_ERR);
   assign err_o    = (st_q == PH_ERR);
   assign part_o   = part_q;
endmodule

// File: rtl/nps_lane_path.sv
module nps_lane_path #(
   parameter int MEM_W  = 8,
   parameter int PART_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              cap_i,
   input  logic [PART_W-1:0] part_i,
   input  logic              byte_only_i,
   input  logic [31:0]       wdata_i,
   input  logic [MEM_W-1:0]  dq_i,
   output logic [MEM_W-1:0]  dq_o,
   output logic [31:0]       rdata_o
);
   localparam int LANES = 32 / MEM_W;

   logic [MEM_W-1:0] lane_q [LANES];
   logic [31:0]      packed_rd;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[g] <= '0;
         else if (clear_i)
            lane_q[g] <= '0;
         else if (cap_i && (part_i == PART_W'(g)))
            lane_q[g] <= dq_i;
      end
      assign packed_rd[g*MEM_W +: MEM_W] = lane_q[g];
   end

   assign dq_o    = wdata_i[part_i*MEM_W +: MEM_W];
   assign rdata_o = byte_only_i ? {24'h0, packed_rd[7:0]} : packed_rd;
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
   import nand_seq_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int MEM_W  = 8,
   parameter int TIM_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [1:0]         req_size,
   input  logic               req_attr,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [31:0]        req_wdata,
   input  logic [4*TIM_W-1:0] tim_cmn,
   input  logic [4*TIM_W-1:0] tim_att,
   output logic               rsp_done,
   output logic               rsp_err,
   output logic [31:0]        rsp_rdata,
   output logic               mem_ce_n,
   output logic               mem_re_n,
   output logic               mem_we_n,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [MEM_W-1:0]   mem_dq_o,
   output logic               mem_dq_oe,
   input  logic [MEM_W-1:0]   mem_dq_i
);
   localparam int LANES  = 32 / MEM_W;
   localparam int PART_W = $clog2(LANES);

   if (!(MEM_W == 8 || MEM_W == 16)) begin : g_bad_width
      $error("nand_phase_seq: MEM_W must be 8 or 16");
   end
   if (TIM_W < 1 || TIM_W > 8) begin : g_bad_tim
      $error("nand_phase_seq: TIM_W out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("nand_phase_seq: ADDR_W too small");
   end

   logic              idle, active, strobe, cap, oe_win, start, refuse;
   logic [PART_W-1:0] part, last_part;
   logic [TIM_W-1:0]  t_setup, t_strobe, t_hold, t_dly;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       wdata_q;
   logic              wr_q, byte_only_q, byte_only;

   // request decode: part count and refusal depend on memory width
   if (MEM_W == 8) begin : g_w8
      assign last_part = (req_size == SZ_WORD) ? PART_W'(3) :
                         (req_size == SZ_HALF) ? PART_W'(1) : PART_W'(0);
      assign refuse    = (req_size == SZ_BAD);
      assign byte_only = 1'b0;
   end else begin : g_w16
      assign last_part = (req_size == SZ_WORD) ? PART_W'(1) : PART_W'(0);
      assign refuse    = (req_size == SZ_BAD) || (req_write && req_size == SZ_BYTE);
      assign byte_only = (req_size == SZ_BYTE);
   end

   assign start = req_valid && idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q      <= '0;
         wdata_q     <= '0;
         wr_q        <= 1'b0;
         byte_only_q <= 1'b0;
      end else if (start) begin
         addr_q      <= req_addr;
         wdata_q     <= req_wdata;
         wr_q        <= req_write;
         byte_only_q <= byte_only;
      end
   end

   nps_cfg_pick #(.TIM_W(TIM_W)) u_pick (
      .sel_att_i (req_attr),
      .cmn_i     (tim_cmn),
      .att_i     (tim_att),
      .setup_o   (t_setup),
      .strobe_o  (t_strobe),
      .hold_o    (t_hold),
      .dly_o     (t_dly)
   );

   nps_phase_fsm #(.TIM_W(TIM_W), .PART_W(PART_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .refuse_i (refuse),
      .last_i   (last_part),
      .setup_i  (t_setup),
      .strobe_i (t_strobe),
      .hold_i   (t_hold),
      .dly_i    (t_dly),
      .idle_o   (idle),
      .active_o (active),
      .strobe_o (strobe),
      .cap_o    (cap),
      .oe_win_o (oe_win),
      .done_o   (rsp_done),
      .err_o    (rsp_err),
      .part_o   (part)
   );

   nps_lane_path #(.MEM_W(MEM_W), .PART_W(PART_W)) u_lanes (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (start),
      .cap_i       (cap && !wr_q),
      .part_i      (part),
      .byte_only_i (byte_only_q),
      .wdata_i     (wdata_q),
      .dq_i        (mem_dq_i),
      .dq_o        (mem_dq_o),
      .rdata_o     (rsp_rdata)
   );

   assign mem_ce_n  = !active;
   assign mem_re_n  = !(strobe && !wr_q);
   assign mem_we_n  = !(strobe && wr_q);
   assign mem_addr  = addr_q + ADDR_W'(part);
   assign mem_dq_oe = oe_win && wr_q;
endmodule

// File: rtl/nps_seq_chk.sv
module nps_seq_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_ce_n,
   input logic              mem_re_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              rsp_done,
   input logic              rsp_err
);
   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_re_n && !mem_we_n));

   // R11
   strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_re_n || !mem_we_n) |-> !mem_ce_n);

   // R6
   refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_done && mem_ce_n && mem_re_n && mem_we_n));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R8
   read_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_re_n |-> !mem_dq_oe);

   // R2
   addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!mem_re_n || !mem_we_n) && $past(!mem_re_n || !mem_we_n)) |-> $stable(mem_addr));

   // R9
   done_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rsp_done) && !rsp_err) |-> $past(!mem_ce_n && mem_re_n && mem_we_n));

   // R7
   oe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_ce_n);
endmodule

bind nand_phase_seq nps_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_ce_n  (mem_ce_n),
   .mem_re_n  (mem_re_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr),
   .rsp_done  (rsp_done),
   .rsp_err   (rsp_err)
);

// File: tb/nand_phase_seq_tb.sv
module nand_phase_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int TW = 4;

   typedef struct {
      bit          is_done;
      bit          err;
      bit          wr;
      logic [23:0] addr;
      int          gap;
      int          len;
      bit          oe;
      logic [15:0] data;
      logic [31:0] rdata;
      string       tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic           v8 = 1'b0, v16 = 1'b0, rq_wr = 1'b0, rq_attr = 1'b0;
   logic [1:0]     rq_size = 2'd0;
   logic [AW-1:0]  rq_addr = '0;
   logic [31:0]    rq_wdata = '0;
   logic [4*TW-1:0] cmn = '0, att = '0;

   logic d8_done, d8_err, d8_ce, d8_re, d8_we, d8_oe;
   logic [31:0] d8_rd;
   logic [AW-1:0] d8_addr;
   logic [7:0] d8_do, d8_di;
   logic d16_done, d16_err, d16_ce, d16_re, d16_we, d16_oe;
   logic [31:0] d16_rd;
   logic [AW-1:0] d16_addr;
   logic [15:0] d16_do, d16_di;

   function automatic logic [15:0] rdv(bit w16, logic [AW-1:0] a);
      return w16 ? {a[7:0] ^ 8'h3C, ~a[7:0]} : {8'h00, a[7:0] ^ 8'hA5};
   endfunction

   logic [15:0] r8w, r16w;
   assign r8w   = rdv(1'b0, d8_addr);
   assign r16w  = rdv(1'b1, d16_addr);
   assign d8_di = r8w[7:0];
   assign d16_di = r16w;

   nand_phase_seq #(.ADDR_W(AW), .MEM_W(8), .TIM_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(v8), .req_write(rq_wr), .req_size(rq_size),
      .req_attr(rq_attr), .req_addr(rq_addr), .req_wdata(rq_wdata), .tim_cmn(cmn), .tim_att(att),
      .rsp_done(d8_done), .rsp_err(d8_err), .rsp_rdata(d8_rd), .mem_ce_n(d8_ce), .mem_re_n(d8_re),
      .mem_we_n(d8_we), .mem_addr(d8_addr), .mem_dq_o(d8_do), .mem_dq_oe(d8_oe), .mem_dq_i(d8_di));

   nand_phase_seq #(.ADDR_W(AW), .MEM_W(16), .TIM_W(TW)) u_dut_w16 (
      .clk(clk), .rst_n(rst_n), .req_valid(v16), .req_write(rq_wr), .req_size(rq_size),
      .req_attr(rq_attr), .req_addr(rq_addr), .req_wdata(rq_wdata), .tim_cmn(cmn), .tim_att(att),
      .rsp_done(d16_done), .rsp_err(d16_err), .rsp_rdata(d16_rd), .mem_ce_n(d16_ce), .mem_re_n(d16_re),
      .mem_we_n(d16_we), .mem_addr(d16_addr), .mem_dq_o(d16_do), .mem_dq_oe(d16_oe), .mem_dq_i(d16_di));

   bit sel16 = 1'b0;
   logic m_ce, m_re, m_we, m_oe, m_done, m_err;
   logic [AW-1:0] m_addr;
   logic [15:0] m_do;
   logic [31:0] m_rd;
   assign m_ce   = sel16 ? d16_ce : d8_ce;
   assign m_re   = sel16 ? d16_re : d8_re;
   assign m_we   = sel16 ? d16_we : d8_we;
   assign m_oe   = sel16 ? d16_oe : d8_oe;
   assign m_done = sel16 ? d16_done : d8_done;
   assign m_err  = sel16 ? d16_err : d8_err;
   assign m_addr = sel16 ? d16_addr : d8_addr;
   assign m_do   = sel16 ? d16_do : {8'h00, d8_do};
   assign m_rd   = sel16 ? d16_rd : d8_rd;

   int n_vec = 0, n_fail = 0, done_cnt = 0;
   bit finished = 1'b0;
   item_t exp_q[$];

   task automatic chk(string tag, string what, longint act, longint exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: rebuilds items from the memory side and compares with the queue
   bit prev_stb = 1'b0;
   int run = 0;
   item_t cur;
   always @(negedge clk) begin
      if (rst_n) begin
         bit stb;
         item_t e;
         stb = !m_re || !m_we;
         if (!m_re && !m_we) chk("R11", "both strobes low", 1, 0);
         if (stb) begin
            if (!prev_stb) begin
               cur.gap = run; cur.len = 1; cur.addr = m_addr; cur.wr = !m_we;
               cur.data = m_do; cur.oe = m_oe; run = 0;
            end else begin
               cur.len++;
            end
         end else if (prev_stb) begin
            if (exp_q.size() == 0) chk("R10", "unexpected strobe pulse", 1, 0);
            else begin
               e = exp_q.pop_front();
               chk(e.tag, "item is pulse", 1, e.is_done ? 0 : 1);
               chk(e.tag, "gap before strobe", cur.gap, e.gap);
               chk(e.tag, "strobe length", cur.len, e.len);
               chk(e.tag, "address", cur.addr, e.addr);
               chk(e.tag, "write strobe", cur.wr, e.wr);
               chk(e.tag, "oe at strobe start", cur.oe, e.oe);
               if (e.wr && e.oe) chk(e.tag, "write data", cur.data, e.data);
            end
            run = !m_ce ? 1 : 0;
         end else if (!m_ce) begin
            run++;
         end
         if (m_done) begin
            if (exp_q.size() == 0) chk("R10", "unexpected done", 1, 0);
            else begin
               e = exp_q.pop_front();
               chk(e.tag, "item is done", 1, e.is_done ? 1 : 0);
               chk(e.tag, "gap before done", run, e.gap);
               chk(e.tag, "error flag", m_err, e.err);
               chk(e.tag, "oe off at done", m_oe, 0);
               if (!e.err && !e.wr) chk(e.tag, "read data", m_rd, e.rdata);
            end
            run = 0;
            done_cnt++;
         end
         prev_stb = stb;
      end
   end

   task automatic xfer(bit w16, bit wr, logic [1:0] sz, bit attr, logic [AW-1:0] a,
                       logic [31:0] wd, string tag, bit poke = 1'b0);
      logic [4*TW-1:0] t;
      int s, w, h, d, np, mw, d0;
      bit refuse;
      logic [31:0] r;
      item_t it;
      t = attr ? att : cmn;
      s = int'(t[TW-1:0]); w = int'(t[2*TW-1:TW]); h = int'(t[3*TW-1:2*TW]); d = int'(t[4*TW-1:3*TW]);
      mw = w16 ? 16 : 8;
      refuse = (sz == 2'd3) || (w16 && wr && sz == 2'd0);
      np = w16 ? ((sz == 2'd2) ? 2 : 1) : ((sz == 2'd2) ? 4 : (sz == 2'd1) ? 2 : 1);
      r = '0;
      it.tag = tag; it.wr = wr; it.rdata = '0; it.data = '0; it.oe = 1'b0; it.addr = '0; it.len = 0;
      if (refuse) begin
         it.is_done = 1'b1; it.err = 1'b1; it.gap = 0;
         exp_q.push_back(it);
      end else begin
         for (int p = 0; p < np; p++) begin
            logic [15:0] rv;
            it.is_done = 1'b0; it.err = 1'b0;
            it.gap  = (p == 0) ? s + 1 : h + 1 + s + 1;
            it.len  = w + 1;
            it.addr = a + AW'(p);
            it.oe   = wr && (d <= s + 1);
            it.data = w16 ? wd[p*16 +: 16] : {8'h00, wd[p*8 +: 8]};
            exp_q.push_back(it);
            rv = rdv(w16, a + AW'(p));
            if (w16) r[p*16 +: 16] = rv;
            else     r[p*8 +: 8]   = rv[7:0];
         end
         if (w16 && sz == 2'd0) r = {16'h0000, 8'h00, r[7:0]};
         it.is_done = 1'b1; it.err = 1'b0; it.gap = h + 1; it.rdata = r;
         exp_q.push_back(it);
      end
      sel16 = w16; rq_wr = wr; rq_size = sz; rq_attr = attr; rq_addr = a; rq_wdata = wd;
      d0 = done_cnt;
      if (w16) v16 = 1'b1; else v8 = 1'b1;
      @(negedge clk);
      v8 = 1'b0; v16 = 1'b0;
      if (poke) begin
         logic [4*TW-1:0] keep;
         keep = cmn;
         repeat (2) @(negedge clk);
         // R10: request while busy plus a new timing word, both must be ignored
         rq_addr = a + 24'h100; rq_wr = !wr; cmn = 16'hF0F0;
         if (w16) v16 = 1'b1; else v8 = 1'b1;
         @(negedge clk);
         v8 = 1'b0; v16 = 1'b0;
         while (done_cnt == d0) @(negedge clk);
         cmn = keep;
      end else begin
         while (done_cnt == d0) @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog: done_count=%0d expected completion", done_cnt);
      summary();
   end

   initial begin
      // fields {dly, hold, strobe, setup}
      cmn = {4'd1, 4'd1, 4'd2, 4'd1};
      att = {4'd5, 4'd2, 4'd0, 4'd3};
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1", "ce_n in reset", d8_ce, 1);
      chk("R1", "we_n in reset", d16_we, 1);
      chk("R1", "done in reset", d8_done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "ce_n idle", d8_ce & d16_ce, 1);
      chk("R1", "re_n idle", d8_re & d16_re, 1);
      chk("R1", "we_n idle", d8_we & d16_we, 1);
      chk("R1", "oe idle", d8_oe | d16_oe, 0);
      chk("R1", "err idle", d8_err | d16_err | d16_done, 0);

      xfer(0, 1, 2'd0, 0, 24'h000010, 32'h0000_005A, "R2");
      xfer(0, 0, 2'd0, 1, 24'h000020, 32'h0,         "R3");
      xfer(0, 1, 2'd1, 0, 24'h000031, 32'h0000_BEEF, "R4");
      xfer(0, 1, 2'd2, 1, 24'h000040, 32'h1234_5678, "R7");
      xfer(0, 0, 2'd2, 0, 24'h0000FE, 32'h0,         "R8");
      xfer(0, 1, 2'd3, 0, 24'h000050, 32'h0,         "R6");
      xfer(1, 1, 2'd1, 0, 24'h000060, 32'h0000_C0DE, "R5");
      xfer(1, 1, 2'd2, 0, 24'h000070, 32'hA1B2_C3D4, "R5");
      xfer(1, 0, 2'd2, 1, 24'h000080, 32'h0,         "R5");
      xfer(1, 0, 2'd0, 0, 24'h000091, 32'h0,         "R8");
      xfer(1, 1, 2'd0, 0, 24'h0000A0, 32'h0000_0077, "R6");
      xfer(1, 0, 2'd1, 0, 24'h0000B3, 32'h0,         "R9");
      cmn = 16'h0000;
      xfer(0, 0, 2'd1, 0, 24'h0000C0, 32'h0,         "R2");
      xfer(0, 1, 2'd2, 0, 24'h0000D0, 32'hCAFE_F00D, "R7");
      cmn = {4'd1, 4'd1, 4'd2, 4'd1};
      xfer(0, 1, 2'd2, 0, 24'h0000E0, 32'h8765_4321, "R10", 1'b1);
      xfer(0, 0, 2'd1, 0, 24'h0000E8, 32'h0,         "R10");
      repeat (10) @(negedge clk);
      chk("R10", "items left over", exp_q.size(), 0);
      chk("R11", "ce_n idle at end", d8_ce & d16_ce, 1);
      summary();
   end
endmodule